// File: doc/BRIEF.md
# Magnitude-Density Gain Control Loop

This block regulates the gain word of a baseband programmable amplifier so that a 2-bit sign/magnitude sampler sees a set fraction of large samples. The block works per channel, for I and for Q. Each ADC sample strobe advances a shared window position. In each window, a per-channel tally counts the samples whose magnitude bit is high. After a full window of 512 strobes, each tally is set against a programmable reference count. The gain word then moves one step toward the target. The target density equals the reference divided by 512, and a reference of 170 gives roughly one third, which suits a 2-bit quantizer.

A 2-bit mode input selects closed-loop or direct operation. In closed-loop mode the two channels run independent loops. In direct mode both gain words follow a programmed gain input. Both reserved codes act as direct mode. Any change of mode restarts the window. A one-cycle update pulse marks each window end. Reset is asynchronous and active low, with its release synchronised upstream.

Top module: `agc_density_loop`

## Requirements
- R1: While and after reset, both gain outputs read 58 (binary 111010) and the update pulse is low.
- R2: In closed-loop mode (mode 00), a window is exactly 512 cycles with the sample strobe high. Cycles with the strobe low neither advance the window nor count, whatever the magnitude inputs. The update pulse is high for exactly the one cycle after the clock edge that takes the 512th strobe.
- R3: If a channel's tally for the window, counting the final strobe's sample, exceeds the reference, that channel's gain falls by one.
- R4: If the tally is below the reference, the gain rises by one.
- R5: If the tally equals the reference, the gain is unchanged.
- R6: The gain saturates: it never falls below 0 and never rises above 63.
- R7: The I and Q loops are independent. Each channel's tally uses only its own magnitude input and drives only its own gain output.
- R8: In closed-loop mode a gain output changes only in the cycle where the update pulse is high.
- R9: In direct mode (mode 10), both gain outputs equal the direct gain input one cycle after it is applied. No update pulse is produced.
- R10: The reserved mode codes 01 and 11 behave exactly like mode 10.
- R11: In the first cycle whose mode differs from the previous cycle's, that cycle's strobe is ignored and the window restarts. On entering closed-loop mode, the gain starts from the last value it held.
- R12: The reference is a 10-bit count over the full range 0 to 512. A tally of 512 against a reference of 512 holds the gain, and against 511 it lowers the gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | ADC sample strobe, one per sample |
| mag_i | input | 1 | I-channel magnitude bit |
| mag_q | input | 1 | Q-channel magnitude bit |
| ref_cnt | input | 10 | Target number of magnitude ones per window |
| mode | input | 2 | 00 closed loop, 10 direct, 01/11 as direct |
| direct_gain | input | 6 | Gain word used in direct mode |
| gain_i | output | 6 | I-channel amplifier gain word, 1 dB per LSB |
| gain_q | output | 6 | Q-channel amplifier gain word, 1 dB per LSB |
| win_done | output | 1 | One-cycle pulse after each completed window |

## Verification
The embedded properties rely on three assumptions:
- The mode, reference and direct gain inputs change only between clock edges.
- The magnitude inputs are don't-care whenever the strobe is low.
- The reference never exceeds the window length.

The stimulus changes every input on the falling clock edge. It draws references from 0 to 512 only. It fills idle cycles with random magnitude bits to show that they are ignored.

Per-window tallies are made exact by placing the ones through an odd-stride permutation of the 512 sample slots. Each window's expected outcome therefore depends only on its chosen tally and the reference.

// File: rtl/agc_pkg.sv
package agc_pkg;

  typedef enum logic [1:0] {
    MODE_LOOP   = 2'b00,
    MODE_RSV_A  = 2'b01,
    MODE_DIRECT = 2'b10,
    MODE_RSV_B  = 2'b11
  } agc_mode_e;

  localparam int unsigned AGC_GAIN_W   = 6;
  localparam int unsigned AGC_WIN_LEN  = 512;
  localparam int unsigned AGC_GAIN_RST = 58;

  function automatic logic is_loop_mode(input logic [1:0] m);
    return (agc_mode_e'(m) == MODE_LOOP);
  endfunction

endpackage

// File: rtl/agc_win_timer.sv
module agc_win_timer #(
  parameter int unsigned WIN_LEN = agc_pkg::AGC_WIN_LEN,
  localparam int unsigned PW = $clog2(WIN_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sample_en,
  output logic win_end
);

  logic [PW-1:0] pos_q, pos_d;
  logic          last_slot;

  assign last_slot = (pos_q == PW'(WIN_LEN - 1));
  assign win_end   = run && sample_en && last_slot;

  always_comb begin
    pos_d = pos_q;
    if (!run) begin
      pos_d = '0;
    end else if (sample_en) begin
      pos_d = last_slot ? '0 : pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= PW'(WIN_LEN - 1));

  // R11
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pos_q == '0));

endmodule

// File: rtl/agc_mag_tally.sv
module agc_mag_tally #(
  parameter int unsigned WIN_LEN = agc_pkg::AGC_WIN_LEN,
  localparam int unsigned CW = $clog2(WIN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          sample_en,
  input  logic          mag,
  input  logic          win_end,
  output logic [CW-1:0] tally
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hit;

  assign hit   = run && sample_en && mag;
  assign tally = cnt_q + CW'(hit);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)            cnt_d = '0;
    else if (win_end)    cnt_d = '0;
    else if (sample_en)  cnt_d = tally;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  tally_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(WIN_LEN - 1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sample_en) |=> $stable(cnt_q));

endmodule

// File: rtl/agc_gain_step.sv
module agc_gain_step #(
  parameter int unsigned GAIN_W   = agc_pkg::AGC_GAIN_W,
  parameter int unsigned GAIN_RST = agc_pkg::AGC_GAIN_RST,
  parameter int unsigned CW       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              direct_mode,
  input  logic              win_end,
  input  logic [CW-1:0]     tally,
  input  logic [CW-1:0]     ref_cnt,
  input  logic [GAIN_W-1:0] direct_gain,
  output logic [GAIN_W-1:0] gain
);

  localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};

  logic [GAIN_W-1:0] gain_q, gain_d, stepped;

  always_comb begin
    stepped = gain_q;
    if (tally > ref_cnt) begin
      if (gain_q != '0) stepped = gain_q - 1'b1;
    end else if (tally < ref_cnt) begin
      if (gain_q != GAIN_MAX) stepped = gain_q + 1'b1;
    end
  end

  always_comb begin
    gain_d = gain_q;
    if (direct_mode)  gain_d = direct_gain;
    else if (win_end) gain_d = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gain_q <= GAIN_W'(GAIN_RST);
    else        gain_q <= gain_d;
  end

  assign gain = gain_q;

  // R8
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(direct_mode) && !$past(win_end)) |-> $stable(gain_q));

  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(direct_mode) |->
      ((gain_q == $past(gain_q)) ||
       ({1'b0, gain_q} == {1'b0, $past(gain_q)} + 1'b1) ||
       ({1'b0, gain_q} + 1'b1 == {1'b0, $past(gain_q)})));

  // R9
  direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(direct_mode) |-> (gain_q == $past(direct_gain)));

endmodule

// File: rtl/agc_density_loop.sv
module agc_density_loop #(
  parameter int unsigned WIN_LEN  = agc_pkg::AGC_WIN_LEN,
  parameter int unsigned GAIN_W   = agc_pkg::AGC_GAIN_W,
  parameter int unsigned GAIN_RST = agc_pkg::AGC_GAIN_RST,
  localparam int unsigned CW = $clog2(WIN_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              mag_i,
  input  logic              mag_q,
  input  logic [CW-1:0]     ref_cnt,
  input  logic [1:0]        mode,
  input  logic [GAIN_W-1:0] direct_gain,
  output logic [GAIN_W-1:0] gain_i,
  output logic [GAIN_W-1:0] gain_q,
  output logic              win_done
);

  localparam int unsigned NCH = 2;

  logic [1:0]        mode_q;
  logic              loop_mode, restart, run, win_end, done_q;
  logic [NCH-1:0]    mag_vec;
  logic [GAIN_W-1:0] gain_vec [NCH];

  assign loop_mode = agc_pkg::is_loop_mode(mode);
  assign restart   = (mode != mode_q);
  assign run       = loop_mode && !restart;
  assign mag_vec   = {mag_q, mag_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      done_q <= 1'b0;
    end else begin
      mode_q <= mode;
      done_q <= win_end;
    end
  end

  agc_win_timer #(.WIN_LEN(WIN_LEN)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sample_en(sample_en),
    .win_end  (win_end)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [CW-1:0] tally;

    agc_mag_tally #(.WIN_LEN(WIN_LEN)) u_tally (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .sample_en(sample_en),
      .mag      (mag_vec[ch]),
      .win_end  (win_end),
      .tally    (tally)
    );

    agc_gain_step #(
      .GAIN_W  (GAIN_W),
      .GAIN_RST(GAIN_RST),
      .CW      (CW)
    ) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .direct_mode(!loop_mode),
      .win_end    (win_end),
      .tally      (tally),
      .ref_cnt    (ref_cnt),
      .direct_gain(direct_gain),
      .gain       (gain_vec[ch])
    );
  end

  assign gain_i   = gain_vec[0];
  assign gain_q   = gain_vec[1];
  assign win_done = done_q;

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !win_done);

  // R9
  loop_only_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> ($past(mode) == 2'b00));

  // R11
  restart_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !win_done);

endmodule

// File: tb/tb_agc_density_loop.sv
module tb_agc_density_loop;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sample_en;
  logic       mag_i, mag_q;
  logic [9:0] ref_cnt;
  logic [1:0] mode;
  logic [5:0] direct_gain;
  logic [5:0] gain_i, gain_q;
  logic       win_done;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_i, exp_q;
  int cycles = 0;

  always #4 clk = ~clk;

  agc_density_loop dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
    .mag_i(mag_i), .mag_q(mag_q), .ref_cnt(ref_cnt), .mode(mode),
    .direct_gain(direct_gain), .gain_i(gain_i), .gain_q(gain_q),
    .win_done(win_done)
  );

  function automatic int step_model(int g, int c, int r);
    if (c > r) return (g > 0) ? g - 1 : 0;
    if (c < r) return (g < 63) ? g + 1 : 63;
    return g;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  // Full window of 512 strobes; ki / kq ones placed by odd-stride permutation.
  task automatic run_window(int ki, int kq, int idle_pct, string req);
    int mult = ($urandom % 256) * 2 + 1;
    int off  = $urandom % 512;
    int early = 0;
    for (int s = 0; s < 512; s++) begin
      while (($urandom % 100) < idle_pct) begin
        @(negedge clk);
        if (win_done) early++;
        sample_en = 1'b0;
        mag_i = 1'($urandom);
        mag_q = 1'($urandom);
      end
      @(negedge clk);
      if (win_done) early++;
      sample_en = 1'b1;
      mag_i = (((s * mult + off) % 512) < ki);
      mag_q = (((s * (mult + 2) + off) % 512) < kq);
    end
    @(negedge clk);
    sample_en = 1'b0;
    exp_i = step_model(exp_i, ki, int'(ref_cnt));
    exp_q = step_model(exp_q, kq, int'(ref_cnt));
    check(early == 0, {req, " R2 no early pulse"}, early, 0);
    check(win_done == 1'b1, {req, " R2 pulse after 512th strobe"}, int'(win_done), 1);
    check(int'(gain_i) == exp_i, {req, " gain_i"}, int'(gain_i), exp_i);
    check(int'(gain_q) == exp_q, {req, " gain_q R7"}, int'(gain_q), exp_q);
  endtask

  task automatic direct_phase(logic [1:0] m, int dg, string req);
    int pulses = 0;
    @(negedge clk);
    mode = m;
    direct_gain = 6'(dg);
    sample_en = 1'b0;
    @(negedge clk);
    check(int'(gain_i) == dg && int'(gain_q) == dg, {req, " direct load"},
          int'(gain_i), dg);
    for (int s = 0; s < 600; s++) begin
      sample_en = 1'b1;
      mag_i = 1'($urandom);
      mag_q = 1'($urandom);
      @(negedge clk);
      if (win_done) pulses++;
    end
    sample_en = 1'b0;
    check(pulses == 0, {req, " no pulse in direct"}, pulses, 0);
    check(int'(gain_q) == dg, {req, " gain held"}, int'(gain_q), dg);
    exp_i = dg;
    exp_q = dg;
  endtask

  // First cycle back in loop mode carries a strobe that must be ignored (R11).
  task automatic enter_loop();
    @(negedge clk);
    mode = 2'b00;
    sample_en = 1'b1;
    mag_i = 1'b1;
    mag_q = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 1'b0;
    sample_en = 1'b0;
    mag_i = 1'b0;
    mag_q = 1'b0;
    ref_cnt = 10'd170;
    mode = 2'b00;
    direct_gain = 6'd0;
    repeat (3) @(negedge clk);
    check(gain_i == 6'd58 && gain_q == 6'd58, "R1 reset gain", int'(gain_i), 58);
    check(win_done == 1'b0, "R1 reset pulse", int'(win_done), 0);
    rst_n = 1'b1;
    exp_i = 58;
    exp_q = 58;
    @(negedge clk);
    check(gain_q == 6'd58, "R1 after release", int'(gain_q), 58);

    run_window(300, 50, 0, "R3 R4");
    run_window(170, 170, 20, "R5");
    run_window(171, 169, 40, "R3 R4 boundary");

    for (int w = 0; w < 20; w++) begin
      int r  = $urandom % 513;
      int ki = ($urandom % 2) ? $urandom % 513 : (r + int'($urandom % 5) - 2);
      int kq = $urandom % 513;
      if (ki < 0) ki = 0;
      if (ki > 512) ki = 512;
      ref_cnt = 10'(r);
      run_window(ki, kq, $urandom % 30, "R3 R4 R5 random");
    end

    ref_cnt = 10'd512;
    run_window(512, 511, 0, "R12 ref 512");
    ref_cnt = 10'd511;
    run_window(512, 511, 10, "R12 ref 511");

    direct_phase(2'b10, 0, "R9");
    ref_cnt = 10'd170;
    enter_loop();
    run_window(0, 0, 0, "R11 restart");
    ref_cnt = 10'd0;
    run_window(10, 0, 0, "R6 low clamp");
    run_window(5, 1, 0, "R6 low clamp hold");

    direct_phase(2'b01, 63, "R10 code 01");
    ref_cnt = 10'd170;
    enter_loop();
    run_window(0, 0, 0, "R6 high clamp");
    direct_phase(2'b11, 21, "R10 code 11");

    // Mid-window mode change: partial window is discarded (R11).
    ref_cnt = 10'd100;
    enter_loop();
    for (int s = 0; s < 300; s++) begin
      @(negedge clk);
      sample_en = 1'b1;
      mag_i = 1'b1;
      mag_q = 1'b1;
    end
    @(negedge clk);
    mode = 2'b10;
    sample_en = 1'b0;
    direct_gain = 6'd21;
    enter_loop();
    run_window(0, 400, 15, "R11 mid-window restart");

    repeat (3) @(negedge clk);
    check(win_done == 1'b0 && int'(gain_i) == exp_i, "R8 quiet hold",
          int'(gain_i), exp_i);
    finish_run();
  end

endmodule